// File: doc/BRIEF.md
# Programmable 16-bit Down-Timer

The block is a down-counting timer with a 16-bit count. It runs from the clock of the block itself. Software sets it up through a small byte-wide register port. There are two count bytes and one control byte. The control byte picks the mode and gates the interrupt request. A start command loads the programmed count and starts the countdown. A start issued while the timer is already counting reloads the count, and the full wait begins again. A stop command halts the timer and drives the output HIGH.

In single-shot mode the output stays HIGH for N clocks after a start, then drops LOW and stays LOW. In periodic mode the count reloads by itself on every timeout. The output goes LOW for one clock per period, so its pulse rate is the clock frequency divided by N. Each timeout can set a sticky interrupt request. A global interrupt encoder elsewhere on the chip collects this request. Software clears it by reading the control byte.

Top module: `pulse_timer16`

## Requirements
- R1: After a synchronous reset the control byte and both count bytes read back 0x00, `tmr_out` is HIGH and `irq` is LOW.
- R2: In single-shot mode (control bit 0 = 0), a start sampled at clock edge E0 keeps `tmr_out` HIGH through edge E0+N-1 and drives it LOW after edge E0+N. N is the 16-bit count: bits 7:0 come from the byte at address 1 and bits 15:8 from the byte at address 2.
- R3: In single-shot mode, once `tmr_out` has dropped it stays LOW until the next start or stop.
- R4: When control bit 1 is 1, a timeout sets `irq` on the same edge that drives the output LOW. When control bit 1 is 0, `irq` does not change on a timeout.
- R5: Reading address 0 shows the pending request in bit 7. That read (`reg_rd` with `reg_addr` = 0) clears `irq` on the next edge, unless a new timeout happens in the same cycle.
- R6: A start while the timer is counting reloads N and keeps `tmr_out` HIGH. The next timeout then comes N edges after that start.
- R7: In periodic mode (control bit 0 = 1), `tmr_out` is LOW for exactly one clock after each of the edges E0+N, E0+2N, … and HIGH otherwise.
- R8: A count of 0 behaves exactly like a count of 1.
- R9: A stop drives `tmr_out` HIGH and halts counting on the next edge, so no timeout and no interrupt follow. When stop and start arrive together, stop wins.
- R10: Writes land on the next edge and read back unchanged in the count bytes. Only bits 1:0 of the control byte are stored; its other bits read as 0, except the pending flag in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears pending request on address 0) |
| reg_addr | input | 2 | Register address: 0 control, 1 count low, 2 count high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| cmd_start | input | 1 | Start or retrigger, one clock wide |
| cmd_stop | input | 1 | Stop and hold output HIGH |
| tmr_out | output | 1 | Timer output level |
| irq | output | 1 | Sticky interrupt request |

## Verification
The assertions assume that `cmd_start` and `cmd_stop` are sampled once per edge as levels. They also assume that the mode bit is not rewritten while a single-shot output is LOW, because the output-hold property is gated by the current mode. The bench keeps to this rule: every command is a single-clock pulse driven on the falling edge, and the mode is changed only after a stop. Reads and writes never share a cycle, and the count bytes are changed only while the timer is idle. This means each expected edge position can be worked out from the last start alone.

// File: rtl/tmr16_pkg.sv
// Package: shared register addresses, control bit positions and mode
// encoding for the 16-bit down-timer. Assumes an 8-bit register port.
package tmr16_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_CNT_LO = 2'd1,
        ADDR_CNT_HI = 2'd2,
        ADDR_RSVD   = 2'd3
    } tmr_addr_e;

    typedef enum logic {
        MODE_ONESHOT  = 1'b0,
        MODE_PERIODIC = 1'b1
    } tmr_mode_e;

    localparam int CTRL_MODE_BIT  = 0;
    localparam int CTRL_IRQEN_BIT = 1;
    localparam int CTRL_PEND_BIT  = 7;

endpackage

// File: rtl/tmr16_regs.sv
// Register file: holds the control byte and the two count bytes, serves
// combinational read data, and produces the effective reload value
// (a zero count is promoted to one). Assumes DATA_W >= 8.
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              irq_pend,
    output logic [DATA_W-1:0] reg_rdata,
    output tmr_mode_e         mode,
    output logic              irq_en,
    output logic              pend_clr,
    output logic [CNT_W-1:0]  reload
);

    logic [DATA_W-1:0] cnt_lo_q;
    logic [DATA_W-1:0] cnt_hi_q;
    logic              mode_q;
    logic              irq_en_q;
    logic [CNT_W-1:0]  raw_cnt;

    // Register writes; only the two defined control bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo_q <= '0;
            cnt_hi_q <= '0;
            mode_q   <= 1'b0;
            irq_en_q <= 1'b0;
        end else if (reg_wr) begin
            case (tmr_addr_e'(reg_addr))
                ADDR_CTRL: begin
                    mode_q   <= reg_wdata[CTRL_MODE_BIT];
                    irq_en_q <= reg_wdata[CTRL_IRQEN_BIT];
                end
                ADDR_CNT_LO: cnt_lo_q <= reg_wdata;
                ADDR_CNT_HI: cnt_hi_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Read data multiplexer, including the pending flag in the control byte.
    always_comb begin
        reg_rdata = '0;
        case (tmr_addr_e'(reg_addr))
            ADDR_CTRL: begin
                reg_rdata[CTRL_MODE_BIT]  = mode_q;
                reg_rdata[CTRL_IRQEN_BIT] = irq_en_q;
                reg_rdata[CTRL_PEND_BIT]  = irq_pend;
            end
            ADDR_CNT_LO: reg_rdata = cnt_lo_q;
            ADDR_CNT_HI: reg_rdata = cnt_hi_q;
            default:     reg_rdata = '0;
        endcase
    end

    // Effective reload value: a zero count acts as one.
    always_comb begin
        raw_cnt = {cnt_hi_q, cnt_lo_q};
        reload  = (raw_cnt == '0) ? CNT_W'(1) : raw_cnt;
    end

    assign mode     = tmr_mode_e'(mode_q);
    assign irq_en   = irq_en_q;
    assign pend_clr = reg_rd && (tmr_addr_e'(reg_addr) == ADDR_CTRL);

endmodule

// File: rtl/tmr16_counter.sv
// Down-counter core: loads the reload value on start, counts while running,
// and flags a timeout on the edge where the count would pass one. Periodic
// mode reloads on timeout; single-shot mode halts. Stop wins over start,
// and start wins over a coincident timeout. Assumes reload is never zero.
module tmr16_counter
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] reload,
    output logic             running,
    output logic             tmo
);

    localparam logic [CNT_W-1:0] TERM = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Timeout event: the last count of a running period, not overridden.
    assign tmo     = run_q && (cnt_q == TERM) && !start && !stop;
    assign running = run_q;

    // Count state and run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (stop) begin
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= reload;
            run_q <= 1'b1;
        end else if (tmo) begin
            if (mode == MODE_PERIODIC) begin
                cnt_q <= reload;
            end else begin
                run_q <= 1'b0;
            end
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/tmr16_output.sv
// Output stage: registers the timer output level and the sticky interrupt
// request. Assumes tmo is a single-cycle event from the counter core.
module tmr16_output
    import tmr16_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      stop,
    input  tmr_mode_e mode,
    input  logic      tmo,
    input  logic      irq_en,
    input  logic      pend_clr,
    output logic      tmr_out,
    output logic      irq
);

    logic out_q;
    logic irq_q;

    // Output level: HIGH on start/stop, LOW on timeout, periodic returns HIGH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b1;
        end else if (start || stop) begin
            out_q <= 1'b1;
        end else if (tmo) begin
            out_q <= 1'b0;
        end else if (mode == MODE_PERIODIC) begin
            out_q <= 1'b1;
        end
    end

    // Interrupt request: set by enabled timeout, cleared by control read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (tmo && irq_en) begin
            irq_q <= 1'b1;
        end else if (pend_clr) begin
            irq_q <= 1'b0;
        end
    end

    assign tmr_out = out_q;
    assign irq     = irq_q;

endmodule

// File: rtl/pulse_timer16.sv
// Top level of the 16-bit single-shot / periodic down-timer. Connects the
// register file, counter core and output stage. Assumes one clock domain,
// single-cycle command pulses and a synchronous active-low reset.
module pulse_timer16
    import tmr16_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    output logic              tmr_out,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    tmr_mode_e        mode_w;
    logic             irq_en_w;
    logic             pend_clr_w;
    logic [CNT_W-1:0] reload_w;
    logic             running_w;
    logic             tmo_w;

    tmr16_regs #(.DATA_W(DATA_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .irq_pend  (irq),
        .reg_rdata (reg_rdata),
        .mode      (mode_w),
        .irq_en    (irq_en_w),
        .pend_clr  (pend_clr_w),
        .reload    (reload_w)
    );

    tmr16_counter #(.CNT_W(CNT_W)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cmd_start),
        .stop    (cmd_stop),
        .mode    (mode_w),
        .reload  (reload_w),
        .running (running_w),
        .tmo     (tmo_w)
    );

    tmr16_output i_output (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_start),
        .stop     (cmd_stop),
        .mode     (mode_w),
        .tmo      (tmo_w),
        .irq_en   (irq_en_w),
        .pend_clr (pend_clr_w),
        .tmr_out  (tmr_out),
        .irq      (irq)
    );

endmodule

// File: rtl/tmr16_checks.sv
// Checker: temporal properties of the down-timer, attached to the top
// through bind. Assumes command inputs are sampled as levels per edge.
module tmr16_checks (
    input logic clk,
    input logic rst_n,
    input logic cmd_start,
    input logic cmd_stop,
    input logic reg_rd,
    input logic [1:0] reg_addr,
    input logic tmr_out,
    input logic irq,
    input logic mode,
    input logic tmo,
    input logic irq_en,
    input logic running
);

    // Single-shot output holds LOW without a command.
    assert_oneshot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !tmr_out && !cmd_start && !cmd_stop) |=> !tmr_out);

    // A stop forces the output HIGH and halts the counter.
    assert_stop_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (tmr_out && !running));

    // A start (without stop) keeps the output HIGH next cycle.
    assert_start_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cmd_stop) |=> tmr_out);

    // Request rises only after an enabled timeout.
    assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(tmo) && $past(irq_en)));

    // Enabled timeout sets the request.
    assert_irq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && irq_en) |=> irq);

    // Control read clears the request when no timeout coincides.
    assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0 && !(tmo && irq_en)) |=> !irq);

    // Every timeout drives the output LOW on the next cycle.
    assert_tmo_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !tmr_out);

endmodule

bind pulse_timer16 tmr16_checks i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .tmr_out   (tmr_out),
    .irq       (irq),
    .mode      (mode_w),
    .tmo       (tmo_w),
    .irq_en    (irq_en_w),
    .running   (running_w)
);

// File: tb/test_pulse_timer16.sv
// Directed bench for the 16-bit down-timer: one task per scenario.
module test_pulse_timer16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       cmd_start = 1'b0;
    logic       cmd_stop = 1'b0;
    logic       tmr_out;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pulse_timer16 i_pulse_timer16 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .tmr_out(tmr_out), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic rd_ctrl();
        @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd0;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
    endtask

    task automatic set_count(input int n);
        wr(2'd1, n[7:0]);
        wr(2'd2, n[15:8]);
    endtask

    // R1: reset state
    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        peek(2'd0, d); check("R1 ctrl", d, 0);
        peek(2'd1, d); check("R1 lo", d, 0);
        peek(2'd2, d); check("R1 hi", d, 0);
        check("R1 out", tmr_out, 1);
        check("R1 irq", irq, 0);
    endtask

    // R10: register readback and masking
    task automatic t_regs();
        logic [7:0] d;
        wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); wr(2'd0, 8'hFF);
        peek(2'd1, d); check("R10 lo", d, 8'hA5);
        peek(2'd2, d); check("R10 hi", d, 8'h3C);
        peek(2'd0, d); check("R10 ctrl mask", d, 8'h03);
        wr(2'd0, 8'h00);
    endtask

    // R2/R3/R4/R5: one-shot timing, hold, interrupt and clear
    task automatic t_oneshot(input int n, input string tag);
        logic [7:0] d;
        wr(2'd0, 8'h02); set_count(n);
        pulse_start();
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            check({tag, " R2 out"}, tmr_out, (i < n) ? 1 : 0);
            check({tag, " R4 irq"}, irq, (i < n) ? 0 : 1);
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); check({tag, " R3 hold"}, tmr_out, 0);
        end
        peek(2'd0, d); check({tag, " R5 pend bit"}, d[7], 1);
        rd_ctrl();
        check({tag, " R5 irq cleared"}, irq, 0);
        peek(2'd0, d); check({tag, " R5 pend cleared"}, d[7], 0);
        pulse_stop();
    endtask

    // R4: interrupt disabled
    task automatic t_noirq();
        wr(2'd0, 8'h00); set_count(3);
        pulse_start();
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            check("R4 no irq", irq, 0);
        end
        check("R4 out low", tmr_out, 0);
        pulse_stop();
    endtask

    // R6: retrigger before timeout
    task automatic t_retrig();
        wr(2'd0, 8'h02); set_count(6);
        pulse_start();
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk); check("R6 pre", tmr_out, 1);
        end
        pulse_start();
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            check("R6 out", tmr_out, (i < 6) ? 1 : 0);
            check("R6 irq", irq, (i < 6) ? 0 : 1);
        end
        rd_ctrl(); pulse_stop();
    endtask

    // R7: periodic pulses
    task automatic t_periodic();
        wr(2'd0, 8'h01); set_count(4);
        pulse_start();
        for (int i = 1; i <= 13; i++) begin
            @(negedge clk);
            check("R7 out", tmr_out, (i % 4 == 0) ? 0 : 1);
        end
        pulse_stop();
        @(negedge clk); check("R7 stopped", tmr_out, 1);
    endtask

    // R8: zero count periodic stays low
    task automatic t_zero_periodic();
        wr(2'd0, 8'h01); set_count(0);
        pulse_start();
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk); check("R8 periodic zero", tmr_out, 0);
        end
        pulse_stop();
    endtask

    // R9: stop mid-run, stop after timeout, stop beats start
    task automatic t_stop();
        wr(2'd0, 8'h02); set_count(5);
        pulse_start();
        @(negedge clk); @(negedge clk);
        pulse_stop();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R9 out held", tmr_out, 1);
            check("R9 irq quiet", irq, 0);
        end
        set_count(2); pulse_start();
        @(negedge clk); @(negedge clk);
        check("R9 fired", tmr_out, 0);
        rd_ctrl(); pulse_stop();
        check("R9 stop high", tmr_out, 1);
        @(negedge clk); cmd_start = 1'b1; cmd_stop = 1'b1;
        @(negedge clk); cmd_start = 1'b0; cmd_stop = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R9 stop wins", tmr_out, 1);
            check("R9 stop wins irq", irq, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_oneshot(5, "N5");
        t_oneshot(0, "R8 zero");
        t_oneshot(259, "R2 bytes");
        t_noirq();
        t_retrig();
        t_periodic();
        t_zero_periodic();
        t_stop();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule